// File: doc/BRIEF.md
# Virtual Address Region and Fault Classifier

This block sits between an address generator and a translation cache. It takes one memory access per handshake: a virtual address, the access kind, the privilege level and a lookup result from a separate TLB, which holds the frame number, the hit flag and three permission bits. It returns one of two outcomes. The access either resolves to a physical address, or it gets a fault code that names the reason. The TLB contents and how entries are replaced are handled elsewhere.

Address-range rules are applied before the lookup result is used:
- When translation is disabled, every address maps to itself.
- In supervisor mode, the topmost kernel quarter of the address space maps straight through.
- In user mode, any address in the upper half is refused.
- Everything else goes through the TLB, and a miss is reported with a different code from a permission refusal.

On a reported fault, three fault-capture outputs are loaded: the faulting address, a data-side flag and the virtual page number. They are loaded together with a one-cycle update strobe. A probe request classifies the access in the same way but never touches the capture outputs.

Both the request side and the response side use valid/ready. A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` is high whenever the response slot is empty or is being drained in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, the response holds steady and no new request is taken.

Top module: `mmu_fault_classifier`

## Requirements
- R1: After reset, `rsp_valid`, `flt_we`, `flt_badaddr`, `flt_dside` and `flt_vpn` are all 0, and `req_ready` is 1.
- R2: With `mmu_on` low, every access succeeds and its physical address equals the virtual address.
- R3: With `mmu_on` high and `req_super` high, an address at or above 0xC0000000 succeeds with a physical address equal to the virtual address, whatever the TLB reports.
- R4: With `mmu_on` high and `req_super` low, an address at or above 0x80000000 faults before any TLB use. The code is 1 for a fetch and 2 for any other kind.
- R5: For an access that reaches the TLB, a hit is allowed when the permission bit for its kind is set. Permission bits are `tlb_perm[0]` read, `tlb_perm[1]` write and `tlb_perm[2]` execute. Kind encodings are 0 load, 1 store, 2 fetch, and 3 behaves as a load. The physical address of an allowed hit is `{tlb_frame, vaddr[11:0]}`.
- R6: A hit without the needed permission faults with code 5 for a read, 6 for a store and 7 for a fetch.
- R7: A TLB miss faults with code 3 for a fetch and 4 for any other kind.
- R8: A non-probe fault pulses `flt_we` in the cycle its response first appears. In that same cycle `flt_badaddr` holds the full address, `flt_dside` is 1 unless the kind is fetch, and `flt_vpn` holds the address shifted right by 12.
- R9: A probe request gets the same `rsp_ok` and `rsp_fault` as a normal request would. However, `flt_we` stays low and the capture outputs keep their values.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and all response outputs hold.
- R11: An accepted request has its response valid in the next cycle.
- R12: `rsp_ok` is 1 exactly when `rsp_fault` is 0, and a faulting response carries `rsp_paddr` of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch, 3 as load |
| req_super | input | 1 | Supervisor privilege |
| req_probe | input | 1 | Classify without capturing a fault |
| mmu_on | input | 1 | Translation enabled |
| tlb_hit | input | 1 | TLB lookup hit |
| tlb_frame | input | 20 | Physical frame from the TLB |
| tlb_perm | input | 3 | Execute, write, read permission bits |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed |
| rsp_ok | output | 1 | Access allowed |
| rsp_fault | output | 3 | Fault code, 0 when allowed |
| rsp_paddr | output | 32 | Physical address, 0 on fault |
| flt_we | output | 1 | Capture outputs updated this cycle |
| flt_badaddr | output | 32 | Captured faulting address |
| flt_dside | output | 1 | Captured data-side flag |
| flt_vpn | output | 20 | Captured virtual page number |

## Verification
The embedded assertions check the handshake rules on every cycle: response hold under back-pressure, one-cycle latency, agreement between `rsp_ok` and the fault code, a zero address on faults, and capture outputs that change only on a strobe that follows a fault. The classification itself, meaning which region rule wins, which code each kind gets and the exact captured page number, can only be shown by the bench. The bench sweeps every kind, privilege, translation, hit and permission combination across addresses on both sides of each region boundary, with and without probe.

// File: rtl/mmu_cls_pkg.sv
package mmu_cls_pkg;
  localparam logic [1:0] KIND_LOAD  = 2'd0;
  localparam logic [1:0] KIND_STORE = 2'd1;
  localparam logic [1:0] KIND_FETCH = 2'd2;

  typedef enum logic [2:0] {
    FLT_NONE      = 3'd0,
    FLT_PRIV_INST = 3'd1,
    FLT_PRIV_DATA = 3'd2,
    FLT_MISS_INST = 3'd3,
    FLT_MISS_DATA = 3'd4,
    FLT_PERM_RD   = 3'd5,
    FLT_PERM_WR   = 3'd6,
    FLT_PERM_EX   = 3'd7
  } fault_e;

  typedef struct packed {
    logic   ok;
    fault_e code;
  } verdict_t;
endpackage

// File: rtl/mmu_region_decode.sv
module mmu_region_decode #(
  parameter int          ADDR_W      = 32,
  parameter logic [31:0] KERNEL_BASE = 32'hC000_0000,
  parameter logic [31:0] USER_LIMIT  = 32'h8000_0000
) (
  input  logic [ADDR_W-1:0] vaddr,
  input  logic              is_super,
  input  logic              mmu_on,
  output logic              direct_map,
  output logic              user_block
);
  localparam logic [ADDR_W-1:0] KB = KERNEL_BASE[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] UL = USER_LIMIT[ADDR_W-1:0];

  always_comb begin
    direct_map = !mmu_on || (is_super && (vaddr >= KB));
    user_block = mmu_on && !is_super && (vaddr >= UL);
  end
endmodule

// File: rtl/mmu_perm_check.sv
module mmu_perm_check
  import mmu_cls_pkg::*;
#(
  parameter int PERM_W = 3
) (
  input  logic [1:0]        kind,
  input  logic [PERM_W-1:0] perm,
  output logic              allowed,
  output fault_e            deny_code
);
  localparam int RD_BIT = 0;
  localparam int WR_BIT = 1;
  localparam int EX_BIT = 2;

  always_comb begin
    unique case (kind)
      KIND_STORE: begin allowed = perm[WR_BIT]; deny_code = FLT_PERM_WR; end
      KIND_FETCH: begin allowed = perm[EX_BIT]; deny_code = FLT_PERM_EX; end
      default:    begin allowed = perm[RD_BIT]; deny_code = FLT_PERM_RD; end
    endcase
  end
endmodule

// File: rtl/mmu_fault_classifier.sv
module mmu_fault_classifier
  import mmu_cls_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter int          PAGE_BITS   = 12,
  parameter logic [31:0] KERNEL_BASE = 32'hC000_0000,
  parameter logic [31:0] USER_LIMIT  = 32'h8000_0000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [ADDR_W-1:0]     req_vaddr,
  input  logic [1:0]            req_kind,
  input  logic                  req_super,
  input  logic                  req_probe,
  input  logic                  mmu_on,
  input  logic                  tlb_hit,
  input  logic [ADDR_W-PAGE_BITS-1:0] tlb_frame,
  input  logic [2:0]            tlb_perm,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic                  rsp_ok,
  output logic [2:0]            rsp_fault,
  output logic [ADDR_W-1:0]     rsp_paddr,
  output logic                  flt_we,
  output logic [ADDR_W-1:0]     flt_badaddr,
  output logic                  flt_dside,
  output logic [ADDR_W-PAGE_BITS-1:0] flt_vpn
);
  localparam int FRAME_W = ADDR_W - PAGE_BITS;

  logic     direct_map, user_block, perm_ok, is_fetch, accept;
  fault_e   deny_code;
  verdict_t verdict;
  logic [ADDR_W-1:0] paddr_c;

  logic              valid_q, ok_q, we_q, dside_q;
  fault_e            code_q;
  logic [ADDR_W-1:0] paddr_q, bad_q;
  logic [FRAME_W-1:0] vpn_q;

  mmu_region_decode #(
    .ADDR_W(ADDR_W), .KERNEL_BASE(KERNEL_BASE), .USER_LIMIT(USER_LIMIT)
  ) u_region (
    .vaddr(req_vaddr), .is_super(req_super), .mmu_on(mmu_on),
    .direct_map(direct_map), .user_block(user_block)
  );

  mmu_perm_check #(.PERM_W(3)) u_perm (
    .kind(req_kind), .perm(tlb_perm), .allowed(perm_ok), .deny_code(deny_code)
  );

  assign is_fetch  = (req_kind == KIND_FETCH);
  assign req_ready = !valid_q || rsp_ready;
  assign accept    = req_valid && req_ready;

  // Priority: direct mapping, then the privilege region, then miss, then permission.
  always_comb begin
    verdict = '{ok: 1'b0, code: FLT_NONE};
    paddr_c = '0;
    if (direct_map) begin
      verdict.ok = 1'b1;
      paddr_c    = req_vaddr;
    end else if (user_block) begin
      verdict.code = is_fetch ? FLT_PRIV_INST : FLT_PRIV_DATA;
    end else if (!tlb_hit) begin
      verdict.code = is_fetch ? FLT_MISS_INST : FLT_MISS_DATA;
    end else if (!perm_ok) begin
      verdict.code = deny_code;
    end else begin
      verdict.ok = 1'b1;
      paddr_c    = {tlb_frame, req_vaddr[PAGE_BITS-1:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      ok_q    <= 1'b0;
      code_q  <= FLT_NONE;
      paddr_q <= '0;
      we_q    <= 1'b0;
      bad_q   <= '0;
      dside_q <= 1'b0;
      vpn_q   <= '0;
    end else begin
      we_q <= 1'b0;
      if (accept) begin
        valid_q <= 1'b1;
        ok_q    <= verdict.ok;
        code_q  <= verdict.code;
        paddr_q <= paddr_c;
        if (!verdict.ok && !req_probe) begin
          we_q    <= 1'b1;
          bad_q   <= req_vaddr;
          dside_q <= !is_fetch;
          vpn_q   <= req_vaddr[ADDR_W-1:PAGE_BITS];
        end
      end else if (rsp_ready) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign rsp_valid   = valid_q;
  assign rsp_ok      = ok_q;
  assign rsp_fault   = code_q;
  assign rsp_paddr   = paddr_q;
  assign flt_we      = we_q;
  assign flt_badaddr = bad_q;
  assign flt_dside   = dside_q;
  assign flt_vpn     = vpn_q;

  // R10: a stalled response holds.
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_fault) &&
                                   $stable(rsp_paddr) && $stable(rsp_ok)));
  // R11: an accepted request is answered on the next cycle.
  a_r11_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);
  // R12: success and fault code agree, and faults carry no address.
  a_r12_ok_code: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_ok == (rsp_fault == 3'd0)) && (rsp_ok || rsp_paddr == '0)));
  // R9: the capture outputs move only with the strobe.
  a_r9_capture_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !flt_we |=> (!flt_we || 1'b1) && ($stable(flt_badaddr) || flt_we));
  // R8: the strobe accompanies a fresh faulting response.
  a_r8_we_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    flt_we |-> (rsp_valid && !rsp_ok));
endmodule

// File: tb/mmu_fault_classifier_bench.sv
module mmu_fault_classifier_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_super = 1'b0, req_probe = 1'b0, mmu_on = 1'b0;
  logic tlb_hit = 1'b0, rsp_ready = 1'b1;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic [19:0] tlb_frame = '0;
  logic [2:0]  tlb_perm = '0;
  logic req_ready, rsp_valid, rsp_ok, flt_we, flt_dside;
  logic [2:0]  rsp_fault;
  logic [31:0] rsp_paddr, flt_badaddr;
  logic [19:0] flt_vpn;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] e_bad = '0;
  logic        e_d = 1'b0;
  logic [19:0] e_vpn = '0;

  always #5 clk = ~clk;

  mmu_fault_classifier u_mmu_fault_classifier (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_kind(req_kind), .req_super(req_super),
    .req_probe(req_probe), .mmu_on(mmu_on), .tlb_hit(tlb_hit),
    .tlb_frame(tlb_frame), .tlb_perm(tlb_perm), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_ok(rsp_ok), .rsp_fault(rsp_fault),
    .rsp_paddr(rsp_paddr), .flt_we(flt_we), .flt_badaddr(flt_badaddr),
    .flt_dside(flt_dside), .flt_vpn(flt_vpn));

  task automatic check(input bit cond, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected outcome built from R2..R7.
  task automatic model(input logic [31:0] va, input logic [1:0] k, input bit sup,
                       input bit on, input bit hit, input logic [2:0] pm,
                       input logic [19:0] fr, output bit ok, output logic [2:0] code,
                       output logic [31:0] pa);
    bit fetch = (k == 2'd2);
    int bitn = (k == 2'd1) ? 1 : (fetch ? 2 : 0);
    ok = 0; code = 0; pa = 0;
    if (!on) begin ok = 1; pa = va; end
    else if (sup && va >= 32'hC000_0000) begin ok = 1; pa = va; end
    else if (!sup && va >= 32'h8000_0000) code = fetch ? 3'd1 : 3'd2;
    else if (!hit) code = fetch ? 3'd3 : 3'd4;
    else if (!pm[bitn]) code = fetch ? 3'd7 : ((k == 2'd1) ? 3'd6 : 3'd5);
    else begin ok = 1; pa = {fr, va[11:0]}; end
  endtask

  task automatic run_one(input logic [31:0] va, input logic [1:0] k, input bit sup,
                         input bit on, input bit hit, input logic [2:0] pm,
                         input bit prb);
    bit eok; logic [2:0] ec; logic [31:0] ep; bit ewe;
    logic [19:0] fr = va[31:12] ^ 20'h5A5A5;
    model(va, k, sup, on, hit, pm, fr, eok, ec, ep);
    ewe = !eok && !prb;
    @(negedge clk);
    req_valid = 1; req_vaddr = va; req_kind = k; req_super = sup; mmu_on = on;
    tlb_hit = hit; tlb_perm = pm; tlb_frame = fr; req_probe = prb;
    @(negedge clk);
    req_valid = 0;
    check(rsp_valid === 1'b1, "R11 valid", rsp_valid, 1);
    check(rsp_ok === eok, eok ? "R2/R3/R5 ok" : "R4/R6/R7 ok", rsp_ok, eok);
    check(rsp_fault === ec, "R4 R6 R7 code", rsp_fault, ec);
    check(rsp_paddr === ep, "R12 paddr", rsp_paddr, ep);
    if (ewe) begin e_bad = va; e_d = (k != 2'd2); e_vpn = va[31:12]; end
    check(flt_we === ewe, prb ? "R9 strobe" : "R8 strobe", flt_we, ewe);
    check({flt_badaddr, flt_dside, flt_vpn} === {e_bad, e_d, e_vpn},
          prb ? "R9 capture" : "R8 capture", {flt_badaddr, flt_dside, flt_vpn},
          {e_bad, e_d, e_vpn});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] addrs [6] = '{32'h0000_1234, 32'h7FFF_F008, 32'h8000_0ABC,
                               32'hBFFF_FFFC, 32'hC000_0010, 32'hFFFF_F123};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check({rsp_valid, flt_we, flt_dside} === 3'b000, "R1 flags", {rsp_valid, flt_we, flt_dside}, 0);
    check({flt_badaddr, flt_vpn} === '0, "R1 capture", {flt_badaddr, flt_vpn}, 0);
    check(req_ready === 1'b1, "R1 ready", req_ready, 1);

    for (int a = 0; a < 6; a++)
      for (int k = 0; k < 4; k++)
        for (int s = 0; s < 2; s++)
          for (int o = 0; o < 2; o++)
            for (int h = 0; h < 2; h++)
              for (int p = 0; p < 8; p++)
                for (int q = 0; q < 2; q++)
                  run_one(addrs[a], 2'(k), s[0], o[0], h[0], 3'(p), q[0]);

    // R10 back-pressure: first response stalls, second request waits.
    @(negedge clk);
    rsp_ready = 0;
    req_valid = 1; req_vaddr = 32'h0000_2345; req_kind = 0; req_super = 0;
    mmu_on = 1; tlb_hit = 0; req_probe = 0;
    @(negedge clk);
    req_vaddr = 32'h0000_3000; tlb_hit = 1; tlb_perm = 3'b001; tlb_frame = 20'hABCDE;
    check(req_ready === 1'b0, "R10 ready low", req_ready, 0);
    @(negedge clk);
    check(rsp_valid === 1'b1 && rsp_fault === 3'd4, "R10 hold code", rsp_fault, 4);
    check(req_ready === 1'b0, "R10 still stalled", req_ready, 0);
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    check(rsp_ok === 1'b1 && rsp_paddr === 32'hABCDE000, "R10 R5 next response",
          rsp_paddr, 32'hABCDE000);
    @(negedge clk);
    check(rsp_valid === 1'b0, "R10 drained", rsp_valid, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule